// File: doc/BRIEF.md
# Six-Phase Accumulator Processor

This block is a very small 8-bit processor built around an accumulator. Every transfer between its registers goes over one shared 8-bit internal bus. The datapath holds the following parts:

- a 4-bit program counter
- a memory address latch
- a 16-byte program/data store
- an instruction latch
- the accumulator
- a second operand register
- an adder/subtracter
- a result register that drives the block's output

Each instruction byte holds a 4-bit operation code in its upper nibble and a 4-bit memory address in its lower nibble. Every instruction takes exactly six clock phases: three to fetch and three to execute.

The store is filled through a write port, and that port works only while the synchronous reset is held. Once reset is released, the program runs from address 0. The program's results appear on `out_value`. A halt instruction freezes the machine and raises `halted`, which stays high until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, accumulator, operand register, result register, phase counter and halt flag clear to zero, so `out_value` reads 0 and `halted` reads 0. In the same state, `load_we`=1 writes `load_data` into store address `load_addr`.
- R2: While `rst` is low, `load_we` has no effect on the store contents.
- R3: The phase counter steps through six phases, 0 to 5, and then wraps. Each instruction therefore occupies exactly six rising edges: instruction n (counting from 1 after reset release) spans edges 6n-5 to 6n.
- R4: Code 0000 (upper nibble) loads the store byte at the address given in the lower nibble into the accumulator.
- R5: Code 0001 copies the addressed byte into the operand register, then writes accumulator + operand, modulo 256, into the accumulator.
- R6: Code 0010 writes accumulator − operand, modulo 256 (two's complement), into the accumulator.
- R7: Code 1110 copies the accumulator into the result register at the fourth edge of its instruction (edge 6n-2). `out_value` changes at no other time, apart from reset.
- R8: Code 1111 raises `halted` at edge 6n-2 of its instruction. After that, `halted` stays high and no register changes until reset.
- R9: Codes 0011 through 1101 change nothing, yet still take all six phases.
- R10: The program counter goes up by one in the second phase of each instruction and wraps from 15 to 0.
- R11: At most one source drives the internal bus in any phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; program loading is allowed while high |
| load_we | input | 1 | Store write strobe, honoured only during reset |
| load_addr | input | 4 | Store address for loading |
| load_data | input | 8 | Byte to load |
| out_value | output | 8 | Result register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench sweeps 256 operand triples. Together they drive the sum and the difference across the modulo-256 boundary in both directions, so a subtracter with a missing carry-in would be off by one, and a wide adder would leak bits. Output and halt timing is checked one edge before and one edge after the expected edge, so a phase counter of the wrong length, or an output latched in the wrong phase, shows up as a wrong value at a named edge. Every unused operation code is run as a do-nothing instruction that must still cost six phases. A seventeen-instruction program runs the program counter past 15, so a counter that saturates instead of wrapping gives the wrong final sum. One run writes through the load port after reset is released, so a store that accepts that write would report the altered operand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int NUM_PHASES = 6;
   localparam int PH_W       = $clog2(NUM_PHASES);

   localparam logic [PH_W-1:0] PH_ADDR  = PH_W'(0);
   localparam logic [PH_W-1:0] PH_INC   = PH_W'(1);
   localparam logic [PH_W-1:0] PH_FETCH = PH_W'(2);
   localparam logic [PH_W-1:0] PH_EX1   = PH_W'(3);
   localparam logic [PH_W-1:0] PH_EX2   = PH_W'(4);
   localparam logic [PH_W-1:0] PH_EX3   = PH_W'(5);

   localparam logic [3:0] OPC_LOAD = 4'h0;
   localparam logic [3:0] OPC_ADD  = 4'h1;
   localparam logic [3:0] OPC_SUB  = 4'h2;
   localparam logic [3:0] OPC_SHOW = 4'hE;
   localparam logic [3:0] OPC_STOP = 4'hF;

   typedef struct packed {
      logic pc;
      logic mem;
      logic ins;
      logic acc;
      logic alu;
   } bus_src_t;

   typedef struct packed {
      bus_src_t src;
      logic     ld_mar;
      logic     ld_ir;
      logic     ld_acc;
      logic     ld_opnd;
      logic     ld_res;
      logic     inc_pc;
      logic     sub;
      logic     set_halt;
   } ctrl_word_t;

endpackage

// File: rtl/acc_cpu_reg.sv
module acc_cpu_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int W    = 8,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   logic [W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (IMPL == 0) begin : g_behav
         assign y = a + b_eff + W'(sub);
      end else begin : g_ripple
         logic [W-1:0] carry;
         assign carry[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign y[i] = a[i] ^ b_eff[i] ^ carry[i];
            if (i < W - 1) begin : g_cy
               assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output logic [PH_W-1:0] phase,
   output logic            halted,
   output ctrl_word_t      cw
);
   logic [PH_W-1:0] phase_q;
   logic            halted_q;
   logic            is_mem_op;

   assign is_mem_op = (opcode == OPC_LOAD) || (opcode == OPC_ADD) || (opcode == OPC_SUB);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= '0;
         halted_q <= 1'b0;
      end else if (!halted_q) begin
         phase_q  <= (phase_q == PH_W'(NUM_PHASES - 1)) ? '0 : phase_q + 1'b1;
         if (cw.set_halt) halted_q <= 1'b1;
      end
   end

   always_comb begin
      cw = '0;
      if (!halted_q) begin
         unique case (phase_q)
            PH_ADDR: begin
               cw.src.pc = 1'b1;
               cw.ld_mar = 1'b1;
            end
            PH_INC: cw.inc_pc = 1'b1;
            PH_FETCH: begin
               cw.src.mem = 1'b1;
               cw.ld_ir   = 1'b1;
            end
            PH_EX1: begin
               if (is_mem_op) begin
                  cw.src.ins = 1'b1;
                  cw.ld_mar  = 1'b1;
               end else if (opcode == OPC_SHOW) begin
                  cw.src.acc = 1'b1;
                  cw.ld_res  = 1'b1;
               end else if (opcode == OPC_STOP) begin
                  cw.set_halt = 1'b1;
               end
            end
            PH_EX2: begin
               if (opcode == OPC_LOAD) begin
                  cw.src.mem = 1'b1;
                  cw.ld_acc  = 1'b1;
               end else if (opcode == OPC_ADD || opcode == OPC_SUB) begin
                  cw.src.mem  = 1'b1;
                  cw.ld_opnd  = 1'b1;
               end
            end
            PH_EX3: begin
               if (opcode == OPC_ADD || opcode == OPC_SUB) begin
                  cw.src.alu = 1'b1;
                  cw.ld_acc  = 1'b1;
                  cw.sub     = (opcode == OPC_SUB);
               end
            end
            default: cw = '0;
         endcase
      end
   end

   assign phase  = phase_q;
   assign halted = halted_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int OP_W     = 4,
   parameter int ALU_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_we,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] out_value,
   output logic              halted
);
   generate
      if (OP_W != 4) begin : g_bad_op
         $error("acc_cpu: OP_W must be 4 to match the operation codes");
      end
      if (DATA_W != OP_W + ADDR_W) begin : g_bad_width
         $error("acc_cpu: DATA_W must equal OP_W + ADDR_W");
      end
      if (ALU_IMPL < 0 || ALU_IMPL > 1) begin : g_bad_alu
         $error("acc_cpu: ALU_IMPL must be 0 or 1");
      end
   endgenerate

   ctrl_word_t        cw;
   bus_src_t          bus_src;
   logic [PH_W-1:0]   phase;
   logic [DATA_W-1:0] bus;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] mar_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] alu_y;

   assign bus_src = cw.src;

   acc_cpu_ctrl #(.OP_W(OP_W)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (ir_q[DATA_W-1 -: OP_W]),
      .phase  (phase),
      .halted (halted),
      .cw     (cw)
   );

   always_ff @(posedge clk) begin
      if (rst)            pc_q <= '0;
      else if (cw.inc_pc) pc_q <= pc_q + 1'b1;
   end

   always_comb begin
      bus = '0;
      if (cw.src.pc)  bus = DATA_W'(pc_q);
      if (cw.src.mem) bus = mem_rd;
      if (cw.src.ins) bus = DATA_W'(ir_q[ADDR_W-1:0]);
      if (cw.src.acc) bus = acc_q;
      if (cw.src.alu) bus = alu_y;
   end

   acc_cpu_reg #(.W(ADDR_W)) u_mar (
      .clk(clk), .rst(rst), .en(cw.ld_mar), .d(bus[ADDR_W-1:0]), .q(mar_q));
   acc_cpu_reg #(.W(DATA_W)) u_ir (
      .clk(clk), .rst(rst), .en(cw.ld_ir), .d(bus), .q(ir_q));
   acc_cpu_reg #(.W(DATA_W)) u_acc (
      .clk(clk), .rst(rst), .en(cw.ld_acc), .d(bus), .q(acc_q));
   acc_cpu_reg #(.W(DATA_W)) u_opnd (
      .clk(clk), .rst(rst), .en(cw.ld_opnd), .d(bus), .q(opnd_q));
   acc_cpu_reg #(.W(DATA_W)) u_res (
      .clk(clk), .rst(rst), .en(cw.ld_res), .d(bus), .q(res_q));

   acc_cpu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (rst & load_we),
      .waddr (load_addr),
      .wdata (load_data),
      .raddr (mar_q),
      .rdata (mem_rd)
   );

   acc_cpu_alu #(.W(DATA_W), .IMPL(ALU_IMPL)) u_alu (
      .a   (acc_q),
      .b   (opnd_q),
      .sub (cw.sub),
      .y   (alu_y)
   );

   assign out_value = res_q;
endmodule

// File: rtl/acc_cpu_check.sv
module acc_cpu_check
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [PH_W-1:0]   phase,
   input logic              halted,
   input logic [ADDR_W-1:0] pc,
   input bus_src_t          bus_src,
   input logic [DATA_W-1:0] out_value
);
   assert_single_driver_R11: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bus_src));

   assert_phase_ring_R3: assert property (@(posedge clk) disable iff (rst)
      !halted |=> (halted ||
         phase == (($past(phase) == PH_W'(NUM_PHASES - 1)) ? '0 : $past(phase) + 1'b1)));

   assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(out_value) && $stable(pc) && $stable(phase)));

   assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
      !halted |=> (pc == (($past(phase) == PH_INC) ? ADDR_W'($past(pc) + 1'b1) : $past(pc))));

   assert_out_phase_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(out_value)) |-> ($past(phase) == PH_EX1));
endmodule

bind acc_cpu acc_cpu_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_check (
   .clk       (clk),
   .rst       (rst),
   .phase     (phase),
   .halted    (halted),
   .pc        (pc_q),
   .bus_src   (bus_src),
   .out_value (out_value)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_we = 1'b0;
   logic [3:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic [7:0] out_value;
   logic       halted;

   int checks = 0;
   int errors = 0;
   logic [7:0] prog [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu uut (
      .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
      .load_data(load_data), .out_value(out_value), .halted(halted)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Hold reset, write all 16 bytes, check the cleared state, release reset.
   task automatic load_prog();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 16; i++) begin
         load_we   = 1'b1;
         load_addr = 4'(i);
         load_data = prog[i];
         @(negedge clk);
      end
      load_we = 1'b0;
      chk("R1 reset out_value", out_value, 8'h00);
      chk("R1 reset halted", {7'b0, halted}, 8'h00);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] x, y, z, s, d;

      // Sweep: load x, add y, show, subtract z, show, stop.
      for (int xi = 0; xi < 16; xi++) begin
         for (int yi = 0; yi < 16; yi++) begin
            x = 8'(xi * 17);
            y = 8'(yi * 19 + 3);
            z = 8'((xi * yi * 7 + 200) ^ (yi << 4));
            s = x + y;
            d = s - z;
            foreach (prog[i]) prog[i] = 8'h00;
            prog[0] = 8'h0E; prog[1] = 8'h1F; prog[2] = 8'hE0;
            prog[3] = 8'h2D; prog[4] = 8'hE0; prog[5] = 8'hF0;
            prog[13] = z; prog[14] = x; prog[15] = y;
            load_prog();
            if (xi == 7 && yi == 2) begin
               // R2: a write after reset release must not reach the store
               step(1);
               load_we = 1'b1; load_addr = 4'd14; load_data = ~x;
               step(1);
               load_we = 1'b0;
               step(13);
            end else begin
               step(15);
            end
            chk("R7 out before show edge", out_value, 8'h00);
            step(1);
            chk((xi == 7 && yi == 2) ? "R2 store untouched after reset" : "R5 sum shown at edge 16",
                out_value, s);
            step(14);
            chk("R6 difference shown", out_value, d);
            step(3);
            chk("R8 halted low before edge 34", {7'b0, halted}, 8'h00);
            step(1);
            chk("R8 halted at edge 34", {7'b0, halted}, 8'h01);
            step(20);
            chk("R8 frozen out_value", out_value, d);
            chk("R8 halted sticky", {7'b0, halted}, 8'h01);
         end
      end

      // R4: plain load then show
      foreach (prog[i]) prog[i] = 8'h00;
      prog[0] = 8'h0E; prog[1] = 8'hE0; prog[2] = 8'hF0; prog[14] = 8'hC3;
      load_prog();
      step(10);
      chk("R4 loaded value shown", out_value, 8'hC3);

      // R9 and R3: every unused code takes six phases and changes nothing
      for (int op = 3; op <= 13; op++) begin
         foreach (prog[i]) prog[i] = 8'h00;
         prog[0] = 8'h0E; prog[1] = {4'(op), 4'hF}; prog[2] = 8'hE0; prog[3] = 8'hF0;
         prog[14] = 8'h21; prog[15] = 8'h99;
         load_prog();
         step(15);
         chk("R9 no early show", out_value, 8'h00);
         step(1);
         chk("R9 accumulator unchanged by no-op", out_value, 8'h21);
         step(5);
         chk("R3 no halt at edge 21", {7'b0, halted}, 8'h00);
         step(1);
         chk("R3 halt at edge 22", {7'b0, halted}, 8'h01);
      end

      // R10: counter wraps from 15 back to 0
      foreach (prog[i]) prog[i] = 8'h30;
      prog[0] = 8'h1F; prog[1] = 8'hE0; prog[15] = 8'h0F;
      load_prog();
      step(12);
      chk("R10 first pass shows 15", out_value, 8'h0F);
      step(93);
      chk("R10 before wrapped show", out_value, 8'h0F);
      step(1);
      chk("R10 after wrap sum is 30", out_value, 8'h1E);
      chk("R10 not halted", {7'b0, halted}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule